// File: doc/BRIEF.md
# Phase Ring Token Checker

This block works with a set of external phase devices that are wired in a closed ring. It drives a one-cycle token onto the ring output and waits for the token to come back on the ring return input. The number of master clock cycles the token spends in the ring gives the number of phases, because each phase device holds the token for one master clock period. While the phase count is being found, and for as long as the block runs, a token that does not come back is sent once more. If a second token is also lost, the block latches an open-ring fault.

After discovery succeeds, the block raises `ready`, which acts as the soft-start permission. It then pulses the ring output once every `phase_cnt` clocks, so that each phase sees one switching period per ring turn. It checks every period that the ring is still closed. The fault stays set until enable is dropped or an off command arrives. All logic uses the master clock and a synchronous active-high reset. The return input is synchronised through `SYNC_STAGES` flops, and its rising edge is detected before it is used.

Top module: `phase_ring_checker`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `ring_out`, `ready` and `open_fault` are 0 and `phase_cnt` is 0.
- R2: The first clock edge that samples `en` high with `clr_cmd` low, from the idle state, sends a token: `ring_out` is 1 for exactly the next cycle.
- R3: If the ring returns the token N cycles after `ring_out` rises (2 <= N <= 16), then `phase_cnt` becomes N and `ready` rises exactly `SYNC_STAGES`+1 cycles after `ring_return` rises. While `ready` is high, `phase_cnt` stays between 2 and 16 and does not change.
- R4: If no valid return has been seen `DISC_WAIT`+`SYNC_STAGES` cycles after a discovery token, a second token is sent `DISC_WAIT`+`SYNC_STAGES`+1 cycles after the first. If the second token returns, discovery succeeds as in R3.
- R5: If the second discovery token is also missed, `open_fault` rises `DISC_WAIT`+`SYNC_STAGES`+1 cycles after the second token. Only two tokens are sent, and afterwards `ring_out` and `ready` stay 0.
- R6: A return that measures below 2 or above 16 cycles counts as a miss, so ring delays of 1, 17 and 20 all end in `open_fault`.
- R7: In run, `ring_out` is a one-cycle pulse repeated every `phase_cnt` cycles.
- R8: In run, a return edge must arrive within `phase_cnt`+`SYNC_STAGES` cycles of the previous return, or of the last token sent. A single miss sends a fresh token and does not set the fault. A return clears the pending miss. A second miss in a row sets `open_fault` and clears `ready`.
- R9: `open_fault` holds while `en` is high and `clr_cmd` is low. `en` low or `clr_cmd` high clears it on the next edge. If `en` is high afterwards, discovery starts again.
- R10: `en` low or `clr_cmd` high forces `ring_out` and `ready` to 0 on the next edge, and no token is sent while that condition lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, equal to switching frequency times phase count |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low stops the block and clears the fault |
| clr_cmd | input | 1 | Off command; high stops the block and clears the fault |
| ring_ret | input | 1 | Token return from the last phase device (asynchronous) |
| ring_out | output | 1 | Token pulse into the first phase device |
| phase_cnt | output | 5 | Discovered phase count |
| ready | output | 1 | Discovery done and ring healthy (soft-start permission) |
| open_fault | output | 1 | Latched open-ring fault |

## Verification
The bench uses the default parameters: up to 16 phases, at least 2 phases, a 30-cycle discovery wait and a two-flop synchroniser. With these values the retry spacing is a fixed 33 cycles and the acceptance window on the return is 4 to 18 cycles. A bench ring model with a settable delay can therefore reach every case in a short run: every legal phase count, delays just outside the range on both sides, an open ring, a ring that closes between the two discovery tokens, and one lost token against a permanent break.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DISC  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } prc_state_e;
endpackage

// File: rtl/prc_sync_edge.sv
// Brings the asynchronous ring return into the clock domain and flags its
// rising edge for one cycle.
module prc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // R3: an edge flag never lasts two cycles
  p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/prc_gap_timer.sv
// Saturating cycle counter restarted by the controller.
module prc_gap_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || restart)   count <= '0;
    else if (count != '1) count <= count + 1'b1;
  end

  // R4: time keeps moving forward until the controller restarts it
  p_gap_moves_r4: assert property (@(posedge clk) disable iff (rst)
    (!restart && count != '1) |=> (count != '0));
endmodule

// File: rtl/phase_ring_checker.sv
module phase_ring_checker
  import prc_pkg::*;
#(
  parameter int MAX_PHASES  = 16,
  parameter int MIN_PHASES  = 2,
  parameter int DISC_WAIT   = 30,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(MAX_PHASES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr_cmd,
  input  logic             ring_ret,
  output logic             ring_out,
  output logic [CNT_W-1:0] phase_cnt,
  output logic             ready,
  output logic             open_fault
);
  localparam int TMR_W = $clog2(DISC_WAIT + MAX_PHASES + SYNC_STAGES + 2);
  localparam logic [TMR_W-1:0] SYNC_T  = TMR_W'(SYNC_STAGES);
  localparam logic [TMR_W-1:0] LO_T    = TMR_W'(MIN_PHASES + SYNC_STAGES);
  localparam logic [TMR_W-1:0] HI_T    = TMR_W'(MAX_PHASES + SYNC_STAGES);
  localparam logic [TMR_W-1:0] DISC_T  = TMR_W'(DISC_WAIT + SYNC_STAGES);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_PHASES);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_PHASES);

  prc_state_e       st;
  logic             ret_rise;
  logic [TMR_W-1:0] gap;
  logic             gap_restart;
  logic [CNT_W-1:0] pc;
  logic             second_try;

  prc_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ring_ret),
    .rise     (ret_rise)
  );

  prc_gap_timer #(.W(TMR_W)) i_gap (
    .clk     (clk),
    .rst     (rst),
    .restart (gap_restart),
    .count   (gap)
  );

  // decision terms
  logic             stop, meas_ok, disc_miss, run_miss, run_tick, launch;
  logic [TMR_W-1:0] run_lim;

  always_comb begin
    stop      = !en || clr_cmd;
    meas_ok   = ret_rise && (gap >= LO_T) && (gap <= HI_T);
    disc_miss = (ret_rise && !meas_ok) || (!ret_rise && gap >= DISC_T);
    run_lim   = TMR_W'(phase_cnt) + SYNC_T;
    run_miss  = !ret_rise && (gap >= run_lim);
    run_tick  = (pc == phase_cnt - ONE_C);
    launch    = 1'b0;
    gap_restart = 1'b0;
    if (stop) begin
      gap_restart = 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: begin
          launch      = 1'b1;
          gap_restart = 1'b1;
        end
        ST_DISC: begin
          launch      = meas_ok || (disc_miss && !second_try);
          gap_restart = meas_ok || disc_miss;
        end
        ST_RUN: begin
          launch      = run_miss ? !second_try : run_tick;
          gap_restart = ret_rise || run_miss;
        end
        default: gap_restart = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ring_out   <= 1'b0;
      phase_cnt  <= '0;
      ready      <= 1'b0;
      open_fault <= 1'b0;
      pc         <= '0;
      second_try <= 1'b0;
    end else begin
      ring_out <= launch;
      if (stop) begin
        st         <= ST_IDLE;
        ready      <= 1'b0;
        open_fault <= 1'b0;
        second_try <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: begin
            st         <= ST_DISC;
            second_try <= 1'b0;
          end
          ST_DISC: begin
            if (meas_ok) begin
              phase_cnt  <= CNT_W'(gap - SYNC_T);
              ready      <= 1'b1;
              st         <= ST_RUN;
              pc         <= '0;
              second_try <= 1'b0;
            end else if (disc_miss) begin
              if (second_try) begin
                st         <= ST_FAULT;
                open_fault <= 1'b1;
              end else begin
                second_try <= 1'b1;
              end
            end
          end
          ST_RUN: begin
            if (run_miss) begin
              if (second_try) begin
                st         <= ST_FAULT;
                open_fault <= 1'b1;
                ready      <= 1'b0;
              end else begin
                second_try <= 1'b1;
                pc         <= '0;
              end
            end else begin
              if (ret_rise) second_try <= 1'b0;
              pc <= run_tick ? '0 : pc + ONE_C;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5: fault and permission never coexist
  p_ready_no_fault_r5: assert property (@(posedge clk) disable iff (rst)
    !(ready && open_fault));
  // R5: no token leaves while the fault is latched
  p_fault_silent_r5: assert property (@(posedge clk) disable iff (rst)
    open_fault |-> !ring_out);
  // R3: a granted count lies in the legal range
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    ready |-> (phase_cnt >= MIN_C && phase_cnt <= MAX_C));
  // R3: the count is frozen while running
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> $stable(phase_cnt));
  // R9: the fault is sticky while enabled and not commanded off
  p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (open_fault && en && !clr_cmd) |=> open_fault);
  // R10: stopping silences the block on the next edge
  p_quiet_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!en || clr_cmd) |=> (!ring_out && !ready && !open_fault));
endmodule

// File: tb/test_phase_ring_checker.sv
`timescale 1ns/1ps
module test_phase_ring_checker;
  logic       clk = 1'b0;
  logic       rst, en, clr_cmd;
  logic       ring_ret;
  logic       ring_out, ready, open_fault;
  logic [4:0] phase_cnt;

  int n_cmp = 0;
  int n_bad = 0;

  // ring model: the token comes back ring_n cycles after it leaves
  logic [31:0] dly;
  int          ring_n  = 5;
  logic        ring_ok = 1'b1;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) dly <= '0;
    else     dly <= {dly[30:0], ring_out};
  end
  assign ring_ret = ring_ok & dly[ring_n-1];

  phase_ring_checker i_phase_ring_checker (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .clr_cmd    (clr_cmd),
    .ring_ret   (ring_ret),
    .ring_out   (ring_out),
    .phase_cnt  (phase_cnt),
    .ready      (ready),
    .open_fault (open_fault)
  );

  localparam int VEC_N = 9;
  localparam int VEC_DLY [VEC_N] = '{2, 3, 5, 8, 11, 16, 1, 17, 20};
  localparam int VEC_EXP [VEC_N] = '{2, 3, 5, 8, 11, 16, 0, 0, 0};

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; clr_cmd = 1'b0;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
  end

  initial begin
    // R1: reset state
    rst = 1'b1; en = 1'b0; clr_cmd = 1'b0;
    cyc(3);
    chk("R1 ring_out", ring_out, 0);
    chk("R1 ready", ready, 0);
    chk("R1 fault", open_fault, 0);
    chk("R1 cnt", phase_cnt, 0);
    rst = 1'b0;
    cyc(1);
    chk("R1 after release", {ring_out, ready, open_fault}, 0);

    // R2 / R3: token timing and exact ready cycle, delay 5
    ring_n = 5; ring_ok = 1'b1;
    en = 1'b1;
    cyc(1);
    chk("R2 token", ring_out, 1);
    cyc(1);
    chk("R2 one cycle", ring_out, 0);
    cyc(6);
    chk("R3 ready not yet", ready, 0);
    cyc(1);
    chk("R3 ready on time", ready, 1);
    chk("R3 count", phase_cnt, 5);

    // vector walk: R3, R6, R7
    for (int v = 0; v < VEC_N; v++) begin
      do_reset();
      ring_n = VEC_DLY[v]; ring_ok = 1'b1;
      en = 1'b1;
      cyc(120);
      if (VEC_EXP[v] != 0) begin
        chk("R3 vec ready", ready, 1);
        chk("R3 vec count", phase_cnt, VEC_EXP[v]);
        chk("R3 vec fault", open_fault, 0);
        begin
          int k = 0;
          while (!ring_out && k < 40) begin cyc(1); k++; end
          k = 0;
          do begin cyc(1); k++; end while (!ring_out && k < 40);
          chk("R7 period", k, VEC_EXP[v]);
        end
      end else begin
        chk("R6 vec fault", open_fault, 1);
        chk("R6 vec ready", ready, 0);
      end
    end

    // R4 / R5: open ring, retry spacing and fault timing
    do_reset();
    ring_n = 5; ring_ok = 1'b0;
    en = 1'b1;
    begin
      int pulses = 0, t1 = -1, t2 = -1, tf = -1;
      for (int i = 0; i < 150; i++) begin
        cyc(1);
        if (ring_out) begin
          pulses++;
          if (t1 < 0) t1 = i; else if (t2 < 0) t2 = i;
        end
        if (open_fault && tf < 0) tf = i;
      end
      chk("R5 two tokens only", pulses, 2);
      chk("R4 retry spacing", t2 - t1, 33);
      chk("R5 fault timing", tf - t2, 33);
      chk("R5 ready low", ready, 0);
    end

    // R9: fault sticky while enabled
    cyc(50);
    chk("R9 fault sticky", open_fault, 1);
    en = 1'b0;
    cyc(1);
    chk("R9 en clears fault", open_fault, 0);
    ring_n = 6; ring_ok = 1'b1;
    en = 1'b1;
    cyc(60);
    chk("R9 rediscover ready", ready, 1);
    chk("R9 rediscover count", phase_cnt, 6);

    // R4: ring closes before the second token returns
    do_reset();
    ring_n = 5; ring_ok = 1'b0;
    en = 1'b1;
    cyc(20);
    ring_ok = 1'b1;
    cyc(60);
    chk("R4 retry success ready", ready, 1);
    chk("R4 retry success count", phase_cnt, 5);
    chk("R4 retry no fault", open_fault, 0);

    // R9: off command clears fault and restarts discovery
    do_reset();
    ring_n = 7; ring_ok = 1'b0;
    en = 1'b1;
    cyc(100);
    chk("R9 fault before off", open_fault, 1);
    ring_ok = 1'b1;
    clr_cmd = 1'b1;
    cyc(1);
    chk("R9 off clears fault", open_fault, 0);
    cyc(5);
    chk("R10 no token while off", ring_out, 0);
    clr_cmd = 1'b0;
    cyc(60);
    chk("R9 after off ready", ready, 1);
    chk("R9 after off count", phase_cnt, 7);

    // R8: one lost token does not fault
    do_reset();
    ring_n = 4; ring_ok = 1'b1;
    en = 1'b1;
    cyc(60);
    ring_ok = 1'b0;
    cyc(4);
    ring_ok = 1'b1;
    cyc(60);
    chk("R8 single miss no fault", open_fault, 0);
    chk("R8 single miss ready", ready, 1);

    // R8: permanent break faults after the second miss
    ring_ok = 1'b0;
    cyc(9);
    chk("R8 first miss tolerated", open_fault, 0);
    cyc(30);
    chk("R8 break faults", open_fault, 1);
    chk("R8 break drops ready", ready, 0);

    // R10: dropping enable in run
    do_reset();
    ring_n = 3; ring_ok = 1'b1;
    en = 1'b1;
    cyc(60);
    chk("R10 running", ready, 1);
    en = 1'b0;
    cyc(1);
    chk("R10 ready off", ready, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        if (ring_out) seen++;
        cyc(1);
      end
      chk("R10 no tokens", seen, 0);
    end

    summary();
  end
endmodule